// File: doc/BRIEF.md
# Wavefront Issue Readiness Scoreboard

Each cycle this block looks at every wavefront slot of every SIMD unit and decides whether the wavefront's next buffered instruction may issue. When it may not, the block gives exactly one reason code. The code comes from a fixed order of checks. Wait-counter, sleep and barrier conditions are tested before buffer occupancy, so a wait or barrier sitting as the last buffered instruction can never lock up its wavefront.

Each wavefront that is ready is steered by its instruction class to one execution resource. The resources are one vector ALU per SIMD, the scalar ALU, global memory, local memory and scalar memory. For each resource the block registers a bitmap of the wavefronts ready for it, and it rebuilds these bitmaps from nothing every cycle.

The block has side outputs for end-of-program handling and barrier release, and it keeps one saturating stall counter per reason code. All outputs are plain per-cycle control and status registers with no handshake: the scheduler samples them each cycle and cannot hold them.

Top module: `wf_issue_scoreboard`

## Requirements
- R1: Wavefront state codes are 0 running, 1 waitcnt, 2 sleep, 3 barrier, 4 stopped, 5 returning, 6 stalled and 7 reserved. Reason codes are 0 ready, 1 stop, 2 buffer empty, 3 waitcnt, 4 sleep, 5 barrier, 6 vector busy and 7 scalar busy. The checks run in this order and the first failing one gives the code:
  - waitcnt state with counters not met (3)
  - sleep state with sleep not done (4)
  - barrier state with barrier not complete (5)
  - stopped, returning, stalled or reserved state (1)
  - buffer empty or no undispatched next instruction (2)
  - vector operands busy (6)
  - scalar operands busy (7)
  - end-of-program handling (3)
- R2: A wavefront that is waiting on counters, sleep or a barrier reports 3, 4 or 5 even when its buffer is empty.
- R3: The stopped, returning, stalled and reserved states report reason 1 and are never ready.
- R4: Vector operand readiness is ignored for scalar instructions. Scalar operand readiness gates every instruction.
- R5: Class 4 is end-of-program. While its sequence number differs from the oldest buffered one, it reports reason 3. Once it is oldest and the earlier checks pass, `wait0_set` pulses for that wavefront. It then reports 3 until `wf_cnt_zero` is set, and is ready after that.
- R6: A barrier-state wavefront whose barrier is complete sets bit `wf_bar_id` of `bar_release` for one cycle, then goes on through the remaining checks.
- R7: Instruction classes map to resources as follows, where ready-list row r holds wavefronts r*NUM_WF+w and wavefront w sits on SIMD w/WF_SLOTS:
  - class 6 (flat) goes to global memory, row NUM_SIMD+1
  - class 7 (local memory) goes to row NUM_SIMD+2
  - class 8 (global memory) goes to row NUM_SIMD+1 for vector instructions and row NUM_SIMD+3 for scalar ones
  - classes 0 to 5 (ALU, branch, nop, return, end-of-program, barrier) go to the wavefront's own SIMD row for vector instructions and row NUM_SIMD (scalar ALU) for scalar ones
- R8: A ready wavefront with a class from 9 to 15 sets `class_err` and appears in no ready list.
- R9: All outputs reflect the inputs of the previous cycle. The ready lists are rebuilt every cycle, and a wavefront appears in at most one list.
- R10: Stall counter k (bits k*CNT_W upward) grows each cycle by the number of wavefronts reporting reason k, and stops at its all-ones value.
- R11: During reset, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wf_state | input | NUM_WF*3 | State code per wavefront |
| wf_cnt_met | input | NUM_WF | Wait counters meet their targets |
| wf_cnt_zero | input | NUM_WF | All outstanding counters are zero |
| wf_sleep_done | input | NUM_WF | Sleep period expired |
| wf_bar_done | input | NUM_WF | All participants reached the barrier |
| wf_bar_id | input | NUM_WF*BAR_W | Barrier id per wavefront |
| wf_buf_empty | input | NUM_WF | Instruction buffer empty |
| wf_next_vld | input | NUM_WF | An undispatched next instruction exists |
| wf_oldest_seq | input | NUM_WF*SEQ_W | Sequence number of oldest buffered entry |
| wf_next_seq | input | NUM_WF*SEQ_W | Sequence number of next instruction |
| wf_iclass | input | NUM_WF*4 | Instruction class of next instruction |
| wf_scalar | input | NUM_WF | Next instruction is scalar |
| wf_vopnd_rdy | input | NUM_WF | Vector operands ready |
| wf_sopnd_rdy | input | NUM_WF | Scalar operands ready |
| ready_list | output | NUM_RES*NUM_WF | Registered ready bitmap per resource |
| wf_reason | output | NUM_WF*3 | Registered reason code per wavefront |
| wait0_set | output | NUM_WF | Enter waitcnt with zero targets |
| bar_release | output | 2**BAR_W | Barrier reset and release pulse per id |
| class_err | output | 1 | Ready wavefront had an unmapped class |
| stall_cnt | output | 8*CNT_W | Saturating stall counter per reason |

## Verification
The bench builds the block with NUM_SIMD=2, WF_SLOTS=2, CNT_W=8, SEQ_W=4 and BAR_W=2. With only four wavefronts, a 14-bit sweep covers every combination of state, class, scalar bit and the six readiness flags on each wavefront, and every resource row is reachable. Eight-bit counters saturate within a few dozen cycles, so the clamp is exercised directly, and a two-bit barrier id lets several wavefronts share one barrier release bit.

// File: rtl/wf_issue_pkg.sv
package wf_issue_pkg;

  typedef enum logic [2:0] {
    RSN_READY   = 3'd0,
    RSN_STOP    = 3'd1,
    RSN_EMPTY   = 3'd2,
    RSN_WAIT    = 3'd3,
    RSN_SLEEP   = 3'd4,
    RSN_BARRIER = 3'd5,
    RSN_VBUSY   = 3'd6,
    RSN_SBUSY   = 3'd7
  } reason_e;

  typedef enum logic [2:0] {
    ST_RUN       = 3'd0,
    ST_WAITCNT   = 3'd1,
    ST_SLEEP     = 3'd2,
    ST_BARRIER   = 3'd3,
    ST_STOPPED   = 3'd4,
    ST_RETURNING = 3'd5,
    ST_STALLED   = 3'd6,
    ST_RSVD      = 3'd7
  } wf_state_e;

  localparam logic [3:0] IC_ALU     = 4'd0;
  localparam logic [3:0] IC_BARRIER = 4'd5;
  localparam logic [3:0] IC_ENDPGM  = 4'd4;
  localparam logic [3:0] IC_FLAT    = 4'd6;
  localparam logic [3:0] IC_LOCAL   = 4'd7;
  localparam logic [3:0] IC_GLOBAL  = 4'd8;

  localparam int NUM_REASONS = 8;
  localparam int RES_EXTRA   = 4;

endpackage

// File: rtl/wf_ready_eval.sv
module wf_ready_eval
  import wf_issue_pkg::*;
#(
  parameter int SEQ_W = 8
) (
  input  logic [2:0]       state,
  input  logic             cnt_met,
  input  logic             cnt_zero,
  input  logic             sleep_done,
  input  logic             bar_done,
  input  logic             buf_empty,
  input  logic             next_vld,
  input  logic [SEQ_W-1:0] oldest_seq,
  input  logic [SEQ_W-1:0] next_seq,
  input  logic [3:0]       iclass,
  input  logic             is_scalar,
  input  logic             vopnd_rdy,
  input  logic             sopnd_rdy,
  output logic [2:0]       reason,
  output logic             bar_hit,
  output logic             wait0
);

  always_comb begin
    reason  = RSN_READY;
    bar_hit = 1'b0;
    wait0   = 1'b0;
    if (state == ST_WAITCNT && !cnt_met) begin
      reason = RSN_WAIT;
    end else if (state == ST_SLEEP && !sleep_done) begin
      reason = RSN_SLEEP;
    end else if (state == ST_BARRIER && !bar_done) begin
      reason = RSN_BARRIER;
    end else begin
      bar_hit = (state == ST_BARRIER);
      if (state >= ST_STOPPED) begin
        reason = RSN_STOP;
      end else if (buf_empty || !next_vld) begin
        reason = RSN_EMPTY;
      end else if (!is_scalar && !vopnd_rdy) begin
        reason = RSN_VBUSY;
      end else if (!sopnd_rdy) begin
        reason = RSN_SBUSY;
      end else if (iclass == IC_ENDPGM) begin
        if (oldest_seq != next_seq) begin
          reason = RSN_WAIT;
        end else begin
          wait0 = 1'b1;
          if (!cnt_zero) reason = RSN_WAIT;
        end
      end
    end
  end

endmodule

// File: rtl/wf_res_map.sv
module wf_res_map
  import wf_issue_pkg::*;
#(
  parameter int NUM_SIMD = 4,
  parameter int SIMD_IDX = 0,
  parameter int RES_W    = 3
) (
  input  logic [3:0]       iclass,
  input  logic             is_scalar,
  output logic [RES_W-1:0] res_idx,
  output logic             map_ok
);

  localparam logic [RES_W-1:0] R_HOME = RES_W'(SIMD_IDX);
  localparam logic [RES_W-1:0] R_SALU = RES_W'(NUM_SIMD);
  localparam logic [RES_W-1:0] R_GMEM = RES_W'(NUM_SIMD + 1);
  localparam logic [RES_W-1:0] R_LMEM = RES_W'(NUM_SIMD + 2);
  localparam logic [RES_W-1:0] R_SMEM = RES_W'(NUM_SIMD + 3);

  always_comb begin
    res_idx = '0;
    map_ok  = 1'b1;
    if (iclass == IC_FLAT) begin
      res_idx = R_GMEM;
    end else if (iclass == IC_LOCAL) begin
      res_idx = R_LMEM;
    end else if (iclass == IC_GLOBAL) begin
      res_idx = is_scalar ? R_SMEM : R_GMEM;
    end else if (iclass <= IC_BARRIER) begin
      res_idx = is_scalar ? R_SALU : R_HOME;
    end else begin
      map_ok = 1'b0;
    end
  end

endmodule

// File: rtl/wf_stall_tally.sv
module wf_stall_tally
  import wf_issue_pkg::*;
#(
  parameter int NUM_WF = 16,
  parameter int CNT_W  = 16
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NUM_WF*3-1:0]           reasons,
  output logic [NUM_REASONS*CNT_W-1:0]  cnt
);

  localparam int INC_W = $clog2(NUM_WF + 1);
  localparam int SUM_W = CNT_W + INC_W;

  logic [INC_W-1:0] inc [NUM_REASONS];

  always_comb begin
    for (int r = 0; r < NUM_REASONS; r++) begin
      inc[r] = '0;
      for (int w = 0; w < NUM_WF; w++) begin
        if (reasons[w*3 +: 3] == 3'(r)) inc[r] = inc[r] + INC_W'(1);
      end
    end
  end

  for (genvar r = 0; r < NUM_REASONS; r++) begin : g_cnt
    logic [CNT_W-1:0] c_q;
    logic [SUM_W-1:0] sum;
    assign sum = SUM_W'(c_q) + SUM_W'(inc[r]);
    always_ff @(posedge clk) begin
      if (!rst_n)                                c_q <= '0;
      else if (sum > SUM_W'({CNT_W{1'b1}}))      c_q <= '1;
      else                                       c_q <= sum[CNT_W-1:0];
    end
    assign cnt[r*CNT_W +: CNT_W] = c_q;
  end

endmodule

// File: rtl/wf_issue_scoreboard.sv
module wf_issue_scoreboard
  import wf_issue_pkg::*;
#(
  parameter int NUM_SIMD = 4,
  parameter int WF_SLOTS = 4,
  parameter int SEQ_W    = 8,
  parameter int BAR_W    = 4,
  parameter int CNT_W    = 16,
  localparam int NUM_WF  = NUM_SIMD * WF_SLOTS,
  localparam int NUM_RES = NUM_SIMD + RES_EXTRA,
  localparam int NUM_BAR = 1 << BAR_W
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [NUM_WF*3-1:0]          wf_state,
  input  logic [NUM_WF-1:0]            wf_cnt_met,
  input  logic [NUM_WF-1:0]            wf_cnt_zero,
  input  logic [NUM_WF-1:0]            wf_sleep_done,
  input  logic [NUM_WF-1:0]            wf_bar_done,
  input  logic [NUM_WF*BAR_W-1:0]      wf_bar_id,
  input  logic [NUM_WF-1:0]            wf_buf_empty,
  input  logic [NUM_WF-1:0]            wf_next_vld,
  input  logic [NUM_WF*SEQ_W-1:0]      wf_oldest_seq,
  input  logic [NUM_WF*SEQ_W-1:0]      wf_next_seq,
  input  logic [NUM_WF*4-1:0]          wf_iclass,
  input  logic [NUM_WF-1:0]            wf_scalar,
  input  logic [NUM_WF-1:0]            wf_vopnd_rdy,
  input  logic [NUM_WF-1:0]            wf_sopnd_rdy,
  output logic [NUM_RES*NUM_WF-1:0]    ready_list,
  output logic [NUM_WF*3-1:0]          wf_reason,
  output logic [NUM_WF-1:0]            wait0_set,
  output logic [NUM_BAR-1:0]           bar_release,
  output logic                         class_err,
  output logic [NUM_REASONS*CNT_W-1:0] stall_cnt
);

  localparam int RES_W = $clog2(NUM_RES);

  logic [2:0]       rsn   [NUM_WF];
  logic [RES_W-1:0] ridx  [NUM_WF];
  logic [NUM_WF-1:0] map_ok, bar_hit, w0;
  logic [NUM_WF*3-1:0] rsn_flat;

  for (genvar w = 0; w < NUM_WF; w++) begin : g_wf
    localparam int SIMD = w / WF_SLOTS;

    wf_ready_eval #(.SEQ_W(SEQ_W)) u_eval (
      .state      (wf_state[w*3 +: 3]),
      .cnt_met    (wf_cnt_met[w]),
      .cnt_zero   (wf_cnt_zero[w]),
      .sleep_done (wf_sleep_done[w]),
      .bar_done   (wf_bar_done[w]),
      .buf_empty  (wf_buf_empty[w]),
      .next_vld   (wf_next_vld[w]),
      .oldest_seq (wf_oldest_seq[w*SEQ_W +: SEQ_W]),
      .next_seq   (wf_next_seq[w*SEQ_W +: SEQ_W]),
      .iclass     (wf_iclass[w*4 +: 4]),
      .is_scalar  (wf_scalar[w]),
      .vopnd_rdy  (wf_vopnd_rdy[w]),
      .sopnd_rdy  (wf_sopnd_rdy[w]),
      .reason     (rsn[w]),
      .bar_hit    (bar_hit[w]),
      .wait0      (w0[w])
    );

    wf_res_map #(.NUM_SIMD(NUM_SIMD), .SIMD_IDX(SIMD), .RES_W(RES_W)) u_map (
      .iclass    (wf_iclass[w*4 +: 4]),
      .is_scalar (wf_scalar[w]),
      .res_idx   (ridx[w]),
      .map_ok    (map_ok[w])
    );

    assign rsn_flat[w*3 +: 3] = rsn[w];
  end

  logic [NUM_RES*NUM_WF-1:0] list_nxt;
  logic [NUM_BAR-1:0]        bar_nxt;
  logic                      err_nxt;

  always_comb begin
    list_nxt = '0;
    bar_nxt  = '0;
    err_nxt  = 1'b0;
    for (int w = 0; w < NUM_WF; w++) begin
      if (rsn[w] == RSN_READY) begin
        if (map_ok[w]) list_nxt[int'(ridx[w]) * NUM_WF + w] = 1'b1;
        else           err_nxt = 1'b1;
      end
      if (bar_hit[w]) bar_nxt[wf_bar_id[w*BAR_W +: BAR_W]] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ready_list  <= '0;
      wf_reason   <= '0;
      wait0_set   <= '0;
      bar_release <= '0;
      class_err   <= 1'b0;
    end else begin
      ready_list  <= list_nxt;
      wf_reason   <= rsn_flat;
      wait0_set   <= w0;
      bar_release <= bar_nxt;
      class_err   <= err_nxt;
    end
  end

  wf_stall_tally #(.NUM_WF(NUM_WF), .CNT_W(CNT_W)) u_tally (
    .clk     (clk),
    .rst_n   (rst_n),
    .reasons (rsn_flat),
    .cnt     (stall_cnt)
  );

endmodule

// File: rtl/wf_issue_scoreboard_chk.sv
module wf_issue_scoreboard_chk
  import wf_issue_pkg::*;
#(
  parameter int NUM_SIMD = 4,
  parameter int WF_SLOTS = 4,
  parameter int CNT_W    = 16,
  localparam int NUM_WF  = NUM_SIMD * WF_SLOTS,
  localparam int NUM_RES = NUM_SIMD + RES_EXTRA
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic [NUM_RES*NUM_WF-1:0]    ready_list,
  input logic [NUM_WF*3-1:0]          wf_reason,
  input logic [NUM_WF-1:0]            wait0_set,
  input logic [NUM_REASONS*CNT_W-1:0] stall_cnt
);

  logic [NUM_RES-1:0] col [NUM_WF];

  always_comb begin
    for (int w = 0; w < NUM_WF; w++)
      for (int r = 0; r < NUM_RES; r++)
        col[w][r] = ready_list[r*NUM_WF + w];
  end

  for (genvar w = 0; w < NUM_WF; w++) begin : g_wf_chk
    localparam logic [NUM_RES-1:0] SIMD_ROWS = NUM_RES'((1 << NUM_SIMD) - 1);
    localparam logic [NUM_RES-1:0] HOME     = NUM_RES'(1) << (w / WF_SLOTS);
    localparam logic [NUM_RES-1:0] FOREIGN  = SIMD_ROWS & ~HOME;

    // R9
    one_list_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(col[w]));

    // R1
    listed_only_if_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|col[w]) |-> (wf_reason[w*3 +: 3] == 3'd0));

    // R5
    wait0_reason_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wait0_set[w] |-> (wf_reason[w*3 +: 3] == 3'd0 || wf_reason[w*3 +: 3] == 3'd3));

    // R7
    home_simd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (col[w] & FOREIGN) == '0);
  end

  for (genvar r = 0; r < NUM_REASONS; r++) begin : g_cnt_chk
    // R10
    no_decrease_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stall_cnt[r*CNT_W +: CNT_W] >= $past(stall_cnt[r*CNT_W +: CNT_W]));
  end

endmodule

bind wf_issue_scoreboard wf_issue_scoreboard_chk #(
  .NUM_SIMD (NUM_SIMD),
  .WF_SLOTS (WF_SLOTS),
  .CNT_W    (CNT_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ready_list (ready_list),
  .wf_reason  (wf_reason),
  .wait0_set  (wait0_set),
  .stall_cnt  (stall_cnt)
);

// File: tb/test_wf_issue_scoreboard.sv
`timescale 1ns/1ps
module test_wf_issue_scoreboard;

  localparam int NS   = 2;
  localparam int SL   = 2;
  localparam int SQW  = 4;
  localparam int BW   = 2;
  localparam int CW   = 8;
  localparam int NW   = NS * SL;
  localparam int NR   = NS + 4;
  localparam int NB   = 1 << BW;
  localparam int CMAX = (1 << CW) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [2:0]     b_st  [NW];
  logic [3:0]     b_cls [NW];
  logic [SQW-1:0] b_old [NW];
  logic [SQW-1:0] b_nxt [NW];
  logic [BW-1:0]  b_bid [NW];
  logic [NW-1:0]  b_met, b_zero, b_slp, b_bar, b_empty, b_nv, b_sc, b_vr, b_sr;

  logic [NW*3-1:0]   p_st;
  logic [NW*4-1:0]   p_cls;
  logic [NW*SQW-1:0] p_old, p_nxt;
  logic [NW*BW-1:0]  p_bid;

  always_comb begin
    for (int w = 0; w < NW; w++) begin
      p_st[w*3 +: 3]      = b_st[w];
      p_cls[w*4 +: 4]     = b_cls[w];
      p_old[w*SQW +: SQW] = b_old[w];
      p_nxt[w*SQW +: SQW] = b_nxt[w];
      p_bid[w*BW +: BW]   = b_bid[w];
    end
  end

  logic [NR*NW-1:0] ready_list;
  logic [NW*3-1:0]  wf_reason;
  logic [NW-1:0]    wait0_set;
  logic [NB-1:0]    bar_release;
  logic             class_err;
  logic [8*CW-1:0]  stall_cnt;

  wf_issue_scoreboard #(
    .NUM_SIMD(NS), .WF_SLOTS(SL), .SEQ_W(SQW), .BAR_W(BW), .CNT_W(CW)
  ) i_wf_issue_scoreboard (
    .clk(clk), .rst_n(rst_n),
    .wf_state(p_st), .wf_cnt_met(b_met), .wf_cnt_zero(b_zero),
    .wf_sleep_done(b_slp), .wf_bar_done(b_bar), .wf_bar_id(p_bid),
    .wf_buf_empty(b_empty), .wf_next_vld(b_nv),
    .wf_oldest_seq(p_old), .wf_next_seq(p_nxt),
    .wf_iclass(p_cls), .wf_scalar(b_sc),
    .wf_vopnd_rdy(b_vr), .wf_sopnd_rdy(b_sr),
    .ready_list(ready_list), .wf_reason(wf_reason), .wait0_set(wait0_set),
    .bar_release(bar_release), .class_err(class_err), .stall_cnt(stall_cnt)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  int mcnt [8];

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // Reference model, written from the requirement text.
  function automatic logic [2:0] ref_reason(input int w);
    if (b_st[w] == 3'd1 && !b_met[w]) return 3'd3;
    if (b_st[w] == 3'd2 && !b_slp[w]) return 3'd4;
    if (b_st[w] == 3'd3 && !b_bar[w]) return 3'd5;
    if (b_st[w] >= 3'd4) return 3'd1;
    if (b_empty[w] || !b_nv[w]) return 3'd2;
    if (!b_sc[w] && !b_vr[w]) return 3'd6;
    if (!b_sr[w]) return 3'd7;
    if (b_cls[w] == 4'd4) begin
      if (b_old[w] != b_nxt[w]) return 3'd3;
      if (!b_zero[w]) return 3'd3;
    end
    return 3'd0;
  endfunction

  function automatic bit ref_wait0(input int w);
    if (b_st[w] == 3'd1 && !b_met[w]) return 0;
    if (b_st[w] == 3'd2 && !b_slp[w]) return 0;
    if (b_st[w] == 3'd3 && !b_bar[w]) return 0;
    if (b_st[w] >= 3'd4 || b_empty[w] || !b_nv[w]) return 0;
    if ((!b_sc[w] && !b_vr[w]) || !b_sr[w]) return 0;
    return (b_cls[w] == 4'd4) && (b_old[w] == b_nxt[w]);
  endfunction

  function automatic int ref_res(input int w);
    int c;
    c = int'(b_cls[w]);
    if (c == 6) return NS + 1;
    if (c == 7) return NS + 2;
    if (c == 8) return b_sc[w] ? NS + 3 : NS + 1;
    if (c <= 5) return b_sc[w] ? NS : w / SL;
    return -1;
  endfunction

  task automatic run_cycle(input string tag);
    logic [NR*NW-1:0] e_list;
    logic [NB-1:0]    e_bar;
    logic [NW-1:0]    e_w0;
    logic             e_err;
    logic [2:0]       e_rsn [NW];
    logic [8*CW-1:0]  e_cnt;
    e_list = '0; e_bar = '0; e_w0 = '0; e_err = 1'b0;
    for (int w = 0; w < NW; w++) begin
      e_rsn[w] = ref_reason(w);
      e_w0[w]  = ref_wait0(w);
      if (b_st[w] == 3'd3 && b_bar[w]) e_bar[b_bid[w]] = 1'b1;
      if (e_rsn[w] == 3'd0) begin
        if (ref_res(w) < 0) e_err = 1'b1;
        else e_list[ref_res(w) * NW + w] = 1'b1;
      end
      mcnt[e_rsn[w]] = (mcnt[e_rsn[w]] >= CMAX) ? CMAX : mcnt[e_rsn[w]] + 1;
    end
    for (int k = 0; k < 8; k++) e_cnt[k*CW +: CW] = CW'(mcnt[k]);
    @(negedge clk);
    for (int w = 0; w < NW; w++) chk(tag, 64'(wf_reason[w*3 +: 3]), 64'(e_rsn[w]));
    chk("R7 ready list", 64'(ready_list), 64'(e_list));
    chk("R5 wait0", 64'(wait0_set), 64'(e_w0));
    chk("R6 barrier release", 64'(bar_release), 64'(e_bar));
    chk("R8 class error", 64'(class_err), 64'(e_err));
    chk("R10 stall counters", 64'(stall_cnt), 64'(e_cnt));
  endtask

  task automatic all_ready();
    for (int w = 0; w < NW; w++) begin
      b_st[w] = 3'd0; b_cls[w] = 4'd0; b_old[w] = '0; b_nxt[w] = '0; b_bid[w] = BW'(w);
    end
    b_met = '1; b_zero = '1; b_slp = '1; b_bar = '0; b_empty = '0;
    b_nv = '1; b_sc = '0; b_vr = '1; b_sr = '1;
  endtask

  initial begin
    for (int k = 0; k < 8; k++) mcnt[k] = 0;
    all_ready();
    repeat (4) @(negedge clk);
    // R11: outputs cleared while in reset
    chk("R11 list", 64'(ready_list), 64'd0);
    chk("R11 reason", 64'(wf_reason), 64'd0);
    chk("R11 counters", 64'(stall_cnt), 64'd0);
    chk("R11 misc", 64'({wait0_set, bar_release, class_err}), 64'd0);
    rst_n = 1'b1;

    // R7: vector ALU work lands on each wavefront's own SIMD row
    run_cycle("R1");
    chk("R7 home rows", 64'(ready_list), 64'h0000_0000_0000_00c3);
    chk("R10 ready count", 64'(stall_cnt[0 +: CW]), 64'd4);

    // R2: waiting states beat an empty buffer
    all_ready(); b_empty = '1;
    b_st[0] = 3'd1; b_met[0] = 1'b0;
    b_st[1] = 3'd2; b_slp[1] = 1'b0;
    b_st[2] = 3'd3; b_bar[2] = 1'b0;
    run_cycle("R2");
    chk("R2 reasons", 64'(wf_reason), 64'(12'b010_101_100_011));

    // R6: barrier complete releases its id and continues to next checks
    all_ready(); b_st[1] = 3'd3; b_bar[1] = 1'b1; b_bid[1] = 2'd2; b_empty[1] = 1'b1;
    run_cycle("R6");
    chk("R6 release bit", 64'(bar_release), 64'b0100);
    chk("R6 then empty", 64'(wf_reason[3 +: 3]), 64'd2);

    // R3: stop-like states
    all_ready(); b_st[0] = 3'd4; b_st[1] = 3'd5; b_st[2] = 3'd6; b_st[3] = 3'd7;
    run_cycle("R3");
    chk("R3 no lists", 64'(ready_list), 64'd0);

    // R4: vector readiness ignored for scalar instructions
    all_ready(); b_vr = '0; b_sc = 4'b0101; b_sr[2] = 1'b0;
    run_cycle("R4");
    chk("R4 reasons", 64'(wf_reason), 64'(12'b110_111_110_000));

    // R5: end-of-program ordering and implicit wait-for-zero
    all_ready(); for (int w = 0; w < NW; w++) b_cls[w] = 4'd4;
    b_nxt[0] = 4'd3; b_zero[1] = 1'b0;
    run_cycle("R5");
    chk("R5 reasons", 64'(wf_reason[5:0]), 64'(6'b011_011));
    chk("R5 pulse", 64'(wait0_set), 64'b1110);

    // R8: unmapped class
    all_ready(); b_cls[3] = 4'd12;
    run_cycle("R8");
    chk("R8 flag", 64'(class_err), 64'd1);

    // R1 and R9: near-exhaustive sweep per wavefront
    for (int i = 0; i < 16384; i++) begin
      for (int w = 0; w < NW; w++) begin
        int j;
        j = (i ^ (w * 5461)) & 16383;
        b_st[w] = 3'(j); b_cls[w] = 4'(j >> 3); b_sc[w] = j[7];
        b_met[w] = j[8]; b_slp[w] = j[9]; b_bar[w] = j[10];
        b_empty[w] = j[11]; b_vr[w] = j[12]; b_sr[w] = j[13];
        b_nv[w] = ($urandom % 8) != 0; b_zero[w] = $urandom % 2 == 0;
        b_old[w] = SQW'($urandom % 4); b_nxt[w] = ($urandom % 2 == 0) ? b_old[w] : SQW'($urandom);
        b_bid[w] = BW'($urandom);
      end
      run_cycle("R1");
    end

    // R10: saturation
    all_ready(); for (int w = 0; w < NW; w++) b_st[w] = 3'd4;
    for (int c = 0; c < 70; c++) run_cycle("R10");
    chk("R10 saturated", 64'(stall_cnt[CW +: CW]), 64'(CMAX));

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule